// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the register side of an eight-line programmable interrupt controller. A byte-wide bus with a single address bit carries initialization words, operation commands and register reads. The block keeps the configuration and in-service state: mask, in-service bits, rotating priority offset, vector base and mode flags. It hands that state to an external priority resolver and request latch. The resolver reports back the winning line (`win_valid`, `win_line`). The latch supplies the raw request bits (`irr_in`) and honours the clear strobes (`req_clr`) that this block issues. The latch alone decides whether a clear applies to a level-triggered line.

Bus requests use valid/ready. A request is taken on any cycle where `bus_valid` and `bus_ready` are both high. A read produces one registered response on `rsp_valid`/`rsp_data`. While a response is held with `rsp_ready` low, `bus_ready` stays low and the response data does not change. The acknowledge port is a plain strobe (`ack_valid`). The vector for the current winner is presented combinationally on `ack_vector` and is valid in the same cycle as the strobe.

All state updates caused in one cycle are applied in a fixed order. The acknowledge goes first, then the bus operation. Register read data always reflects the state held before that cycle's updates.

Top module: `icd_ctrl`

## Requirements
- R1: A write to address 0 with bit 4 set clears mask, in-service, offset, vector base, read-select, poll, special-mask, auto-EOI, rotate-on-auto-EOI and special-nested state. It pulses `req_clr` with all ones, forces `int_req` low on the next cycle, and enters the base-word step. Data bit 0 records whether a fourth word follows. Outside initialization, `int_req` is a one-cycle-delayed copy of `win_valid`.
- R2: Address-1 writes during initialization proceed through three steps. The base step loads the vector base from data bits 7:3. The cascade step is consumed and moves on: to the mode step if a fourth word was requested, otherwise to normal operation. The mode step loads special-nested from bit 4 and auto-EOI from bit 1, then returns to normal operation.
- R3: In normal operation a write to address 1 loads the mask register with the data byte.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 permits loading read-select from bit 0. Bit 6 permits loading special-mask from bit 5. When a permit bit is clear, the corresponding field is unchanged.
- R5: An address-0 command with bit 4 clear, bit 3 clear and bits 7:5 equal to 0 or 4 sets rotate-on-auto-EOI to data bit 7.
- R6: Command code 1 clears the in-service bit that ranks highest, counting upward from the offset. Code 5 does the same and then sets the offset to that line plus 1. With no in-service bit set, both codes change nothing.
- R7: Code 3 clears the in-service bit selected by data bits 2:0. Code 6 sets the offset to data bits 2:0 plus 1, modulo 8. Code 7 does both for the line in bits 2:0. Code 2 changes nothing.
- R8: An acknowledge with a winner sets that line's in-service bit and pulses its `req_clr` bit. `ack_vector` equals the base in bits 7:3 and the line in bits 2:0.
- R9: In auto-EOI mode an acknowledge leaves the line's in-service bit clear. If rotate-on-auto-EOI is set, the offset becomes the line plus 1, modulo 8.
- R10: An acknowledge with no winner yields `ack_vector` equal to base plus 7. It leaves in-service and offset unchanged and issues no clear.
- R11: A non-poll read of address 0 returns in-service when read-select is 1 and `irr_in` when it is 0. A read of address 1 returns the mask.
- R12: With poll armed, the next read at either address returns the winning line and clears that line's in-service bit, pulsing its `req_clr` bit. With no winner it returns 7 and changes nothing. In both cases the read disarms the poll.
- R13: When an acknowledge and a bus write occur in the same cycle, the acknowledge's effect is applied before the write's.
- R14: While `rsp_valid` is high and `rsp_ready` is low, the response data holds and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request can be taken |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumer ready |
| rsp_data | output | 8 | Read response data |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_vector | output | 8 | Vector for the current winner or spurious vector |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line number |
| irr_in | input | 8 | Request bits from the external latch |
| req_clr | output | 8 | One-cycle per-line request clear strobe |
| int_req | output | 1 | Interrupt output toward the processor |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| prio_off | output | 3 | Rotating priority offset (line ranked highest) |
| sfnm_o | output | 1 | Special fully nested flag |
| smask_o | output | 1 | Special mask flag |

## Verification
An acknowledge and a bus write can land in the same cycle, and both can touch the in-service bits and the offset. The bench sets up a case where order matters: line 5 is in service and the offset is 0. It then acknowledges line 2 in the same cycle as a non-specific end-of-interrupt. Ack-first ordering leaves only line 5 in service, while the reverse order would leave only line 2. Random runs also issue strobes and writes together, and every resulting state is compared with a bench model that applies the acknowledge first.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int BYTE_W = 8;
  // control-word bit positions (decoded behaviour)
  localparam int B_INIT   = 4;
  localparam int B_MODE   = 3;
  localparam int B_POLL   = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL   = 0;
  localparam int B_SMASK_EN = 6;
  localparam int B_SMASK  = 5;
  localparam int B_NEED4  = 0;
  localparam int B_SFNM   = 4;
  localparam int B_AEOI   = 1;
  localparam int B_ROTAE  = 7;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  typedef enum logic [2:0] {
    OP_ROT0  = 3'd0,
    OP_EOI   = 3'd1,
    OP_NOP   = 3'd2,
    OP_SEOI  = 3'd3,
    OP_ROT1  = 3'd4,
    OP_REOI  = 3'd5,
    OP_SETP  = 3'd6,
    OP_RSEOI = 3'd7
  } opc_t;

  typedef struct packed {
    logic init;
    logic mode;
    logic op;
    logic wr1;
    opc_t opc;
  } icd_dec_t;
endpackage

// File: rtl/icd_rot_pick.sv
module icd_rot_pick #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [LW-1:0] off,
  output logic          found,
  output logic [LW-1:0] line
);
  // Scan from lowest rank to highest so the last hit is the top-ranked line.
  always_comb begin
    logic [LW-1:0] idx;
    found = 1'b0;
    line  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = off + LW'(i);
      if (mask[idx]) begin
        found = 1'b1;
        line  = idx;
      end
    end
  end
endmodule

// File: rtl/icd_cmd_decode.sv
module icd_cmd_decode
  import icd_pkg::*;
(
  input  logic              wr_fire,
  input  logic              addr,
  input  logic [BYTE_W-1:0] data,
  output icd_dec_t          dec
);
  logic a0;
  assign a0 = wr_fire && !addr;

  always_comb begin
    dec.init = a0 && data[B_INIT];
    dec.mode = a0 && !data[B_INIT] && data[B_MODE];
    dec.op   = a0 && !data[B_INIT] && !data[B_MODE];
    dec.wr1  = wr_fire && addr;
    dec.opc  = opc_t'(data[BYTE_W-1 -: 3]);
  end
endmodule

// File: rtl/icd_state.sv
module icd_state
  import icd_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES),
  localparam int BW = BYTE_W - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  icd_dec_t          dec,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ack_fire,
  input  logic              poll_fire,
  input  logic              win_valid,
  input  logic [LW-1:0]     win_line,
  output logic [NLINES-1:0] isr,
  output logic [NLINES-1:0] imr,
  output logic [LW-1:0]     off,
  output logic [BW-1:0]     base,
  output logic              aeoi,
  output logic              rot_aeoi,
  output logic              sfnm,
  output logic              smask,
  output logic              rsel,
  output logic              poll,
  output seq_t              seq,
  output logic              int_req,
  output logic [NLINES-1:0] req_clr
);
  logic [NLINES-1:0] isr_a, clr_a, isr_n, imr_n, clr_n;
  logic [LW-1:0]     off_a, off_n, arg_line;
  logic [BW-1:0]     base_n;
  logic              aeoi_n, rot_n, sfnm_n, smask_n, rsel_n, poll_n, need4, need4_n;
  seq_t              seq_n;
  logic              eoi_found;
  logic [LW-1:0]     eoi_line;

  assign arg_line = wdata[LW-1:0];

  // Stage 1: acknowledge effects.
  always_comb begin
    isr_a = isr;
    off_a = off;
    clr_a = '0;
    if (ack_fire && win_valid) begin
      isr_a[win_line] = 1'b1;
      clr_a[win_line] = 1'b1;
      if (aeoi) begin
        isr_a[win_line] = 1'b0;
        if (rot_aeoi) off_a = win_line + LW'(1);
      end
    end
  end

  // Highest-ranked in-service line after the acknowledge.
  icd_rot_pick #(.N(NLINES)) u_eoi_pick (
    .mask (isr_a),
    .off  (off_a),
    .found(eoi_found),
    .line (eoi_line)
  );

  // Stage 2: bus operation effects on top of stage 1.
  always_comb begin
    isr_n   = isr_a;
    off_n   = off_a;
    clr_n   = clr_a;
    imr_n   = imr;
    base_n  = base;
    aeoi_n  = aeoi;
    rot_n   = rot_aeoi;
    sfnm_n  = sfnm;
    smask_n = smask;
    rsel_n  = rsel;
    poll_n  = poll;
    seq_n   = seq;
    need4_n = need4;
    if (poll_fire) begin
      poll_n = 1'b0;
      if (win_valid) begin
        isr_n[win_line] = 1'b0;
        clr_n[win_line] = 1'b1;
      end
    end
    if (dec.init) begin
      isr_n   = '0;
      off_n   = '0;
      clr_n   = '1;
      imr_n   = '0;
      base_n  = '0;
      aeoi_n  = 1'b0;
      rot_n   = 1'b0;
      sfnm_n  = 1'b0;
      smask_n = 1'b0;
      rsel_n  = 1'b0;
      poll_n  = 1'b0;
      seq_n   = SEQ_BASE;
      need4_n = wdata[B_NEED4];
    end else if (dec.mode) begin
      if (wdata[B_POLL])     poll_n  = 1'b1;
      if (wdata[B_RSEL_EN])  rsel_n  = wdata[B_RSEL];
      if (wdata[B_SMASK_EN]) smask_n = wdata[B_SMASK];
    end else if (dec.op) begin
      unique case (dec.opc)
        OP_ROT0, OP_ROT1: rot_n = wdata[B_ROTAE];
        OP_EOI, OP_REOI: begin
          if (eoi_found) begin
            isr_n[eoi_line] = 1'b0;
            if (dec.opc == OP_REOI) off_n = eoi_line + LW'(1);
          end
        end
        OP_SEOI: isr_n[arg_line] = 1'b0;
        OP_SETP: off_n = arg_line + LW'(1);
        OP_RSEOI: begin
          off_n = arg_line + LW'(1);
          isr_n[arg_line] = 1'b0;
        end
        default: ;
      endcase
    end else if (dec.wr1) begin
      unique case (seq)
        SEQ_RUN:  imr_n = wdata[NLINES-1:0];
        SEQ_BASE: begin
          base_n = wdata[BYTE_W-1:LW];
          seq_n  = SEQ_CASC;
        end
        SEQ_CASC: seq_n = need4 ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: begin
          sfnm_n = wdata[B_SFNM];
          aeoi_n = wdata[B_AEOI];
          seq_n  = SEQ_RUN;
        end
        default: seq_n = SEQ_RUN;
      endcase
    end
  end

  assign req_clr = clr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr      <= '0;
      imr      <= '0;
      off      <= '0;
      base     <= '0;
      aeoi     <= 1'b0;
      rot_aeoi <= 1'b0;
      sfnm     <= 1'b0;
      smask    <= 1'b0;
      rsel     <= 1'b0;
      poll     <= 1'b0;
      seq      <= SEQ_RUN;
      need4    <= 1'b0;
      int_req  <= 1'b0;
    end else begin
      isr      <= isr_n;
      imr      <= imr_n;
      off      <= off_n;
      base     <= base_n;
      aeoi     <= aeoi_n;
      rot_aeoi <= rot_n;
      sfnm     <= sfnm_n;
      smask    <= smask_n;
      rsel     <= rsel_n;
      poll     <= poll_n;
      seq      <= seq_n;
      need4    <= need4_n;
      int_req  <= dec.init ? 1'b0 : win_valid;
    end
  end
endmodule

// File: rtl/icd_ctrl.sv
module icd_ctrl
  import icd_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES),
  localparam int BW = BYTE_W - LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              ack_valid,
  output logic [BYTE_W-1:0] ack_vector,
  input  logic              win_valid,
  input  logic [LW-1:0]     win_line,
  input  logic [NLINES-1:0] irr_in,
  output logic [NLINES-1:0] req_clr,
  output logic              int_req,
  output logic [NLINES-1:0] isr_o,
  output logic [NLINES-1:0] imr_o,
  output logic [LW-1:0]     prio_off,
  output logic              sfnm_o,
  output logic              smask_o
);
  logic        bus_fire, wr_fire, rd_fire, poll_fire;
  icd_dec_t    dec;
  logic [BW-1:0] base_q;
  logic        aeoi_q, rot_q, rsel_q, poll_q;
  seq_t        seq_q;
  logic [LW-1:0] line_or_spur;
  logic [BYTE_W-1:0] rd_mux;

  assign bus_ready = !rsp_valid || rsp_ready;
  assign bus_fire  = bus_valid && bus_ready;
  assign wr_fire   = bus_fire && bus_write;
  assign rd_fire   = bus_fire && !bus_write;
  assign poll_fire = rd_fire && poll_q;

  icd_cmd_decode u_dec (
    .wr_fire(wr_fire),
    .addr   (bus_addr),
    .data   (bus_wdata),
    .dec    (dec)
  );

  icd_state #(.NLINES(NLINES)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .wdata    (bus_wdata),
    .ack_fire (ack_valid),
    .poll_fire(poll_fire),
    .win_valid(win_valid),
    .win_line (win_line),
    .isr      (isr_o),
    .imr      (imr_o),
    .off      (prio_off),
    .base     (base_q),
    .aeoi     (aeoi_q),
    .rot_aeoi (rot_q),
    .sfnm     (sfnm_o),
    .smask    (smask_o),
    .rsel     (rsel_q),
    .poll     (poll_q),
    .seq      (seq_q),
    .int_req  (int_req),
    .req_clr  (req_clr)
  );

  assign line_or_spur = win_valid ? win_line : '1;
  assign ack_vector   = {base_q, line_or_spur};

  always_comb begin
    if (poll_q)        rd_mux = BYTE_W'(line_or_spur);
    else if (bus_addr) rd_mux = BYTE_W'(imr_o);
    else if (rsel_q)   rd_mux = BYTE_W'(isr_o);
    else               rd_mux = BYTE_W'(irr_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/icd_ctrl_chk.sv
module icd_ctrl_chk
  import icd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       bus_write,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       ack_valid,
  input logic       win_valid,
  input logic [2:0] win_line,
  input logic [7:0] isr_o,
  input logic [7:0] imr_o,
  input logic [2:0] prio_off,
  input logic       int_req,
  input logic       aeoi,
  input seq_t       seq
);
  logic fire;
  assign fire = bus_valid && bus_ready;

  // R14
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bus_write && !bus_addr && bus_wdata[4]
    |=> isr_o == 8'h00 && imr_o == 8'h00 && prio_off == 3'd0 && !int_req);

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bus_write && bus_addr && seq == SEQ_RUN
    |=> imr_o == $past(bus_wdata));

  // R8
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && win_valid && !aeoi && !fire |=> isr_o[$past(win_line)]);

  // R10
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !win_valid && !fire |=> $stable(isr_o) && $stable(prio_off));
endmodule

bind icd_ctrl icd_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .ack_valid(ack_valid),
  .win_valid(win_valid),
  .win_line (win_line),
  .isr_o    (isr_o),
  .imr_o    (imr_o),
  .prio_off (prio_off),
  .int_req  (int_req),
  .aeoi     (aeoi_q),
  .seq      (seq_q)
);

// File: tb/icd_ctrl_bench.sv
`timescale 1ns/1ps
module icd_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0, bus_addr = 0, rsp_ready = 1, ack_valid = 0, win_valid = 0;
  logic [7:0] bus_wdata = '0, irr_in = '0;
  logic [2:0] win_line = '0;
  logic bus_ready, rsp_valid, int_req, sfnm_o, smask_o;
  logic [7:0] rsp_data, ack_vector, req_clr, isr_o, imr_o;
  logic [2:0] prio_off;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  logic [7:0] m_isr, m_imr;
  logic [2:0] m_off;
  logic [4:0] m_base;
  bit m_aeoi, m_rot, m_sfnm, m_smask, m_rsel, m_poll, m_need4;
  int m_seq;

  always #2 clk = ~clk;

  icd_ctrl u_icd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .win_valid(win_valid),
    .win_line(win_line), .irr_in(irr_in), .req_clr(req_clr), .int_req(int_req),
    .isr_o(isr_o), .imr_o(imr_o), .prio_off(prio_off), .sfnm_o(sfnm_o), .smask_o(smask_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int top_line(input logic [7:0] mask, input logic [2:0] off);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] k;
      k = off + 3'(i);
      if (mask[k]) return int'(k);
    end
    return 8;
  endfunction

  task automatic model_reset();
    m_isr = 0; m_imr = 0; m_off = 0; m_base = 0; m_aeoi = 0; m_rot = 0;
    m_sfnm = 0; m_smask = 0; m_rsel = 0; m_poll = 0; m_need4 = 0; m_seq = 0;
  endtask

  // One operation: optional bus request plus optional acknowledge in one cycle.
  task automatic op(input bit bv, input bit bw, input bit ba, input logic [7:0] bd,
                    input bit av, input bit wv, input logic [2:0] wl,
                    input logic [7:0] ir, input string tag);
    logic [7:0] e_clr, e_vec, e_rsp, isr;
    logic [2:0] off;
    bit is_init, is_rd;
    int h;
    @(negedge clk);
    bus_valid = bv; bus_write = bw; bus_addr = ba; bus_wdata = bd;
    ack_valid = av; win_valid = wv; win_line = wl; irr_in = ir;
    #1;
    e_vec = {m_base, wv ? wl : 3'd7};
    e_clr = 0; e_rsp = 0;
    isr = m_isr; off = m_off;
    is_init = bv && bw && !ba && bd[4];
    is_rd = bv && !bw;
    if (av && wv) begin
      isr[wl] = 1; e_clr[wl] = 1;
      if (m_aeoi) begin isr[wl] = 0; if (m_rot) off = wl + 3'd1; end
    end
    if (is_rd) begin
      if (m_poll) begin
        e_rsp = wv ? {5'd0, wl} : 8'd7;
        if (wv) begin isr[wl] = 0; e_clr[wl] = 1; end
        m_poll = 0;
      end else e_rsp = ba ? m_imr : (m_rsel ? m_isr : ir);
    end
    if (bv && bw) begin
      if (is_init) begin
        isr = 0; off = 0; e_clr = 8'hFF; m_imr = 0; m_base = 0; m_aeoi = 0; m_rot = 0;
        m_sfnm = 0; m_smask = 0; m_rsel = 0; m_poll = 0; m_seq = 1; m_need4 = bd[0];
      end else if (!ba && bd[3]) begin
        if (bd[2]) m_poll = 1;
        if (bd[1]) m_rsel = bd[0];
        if (bd[6]) m_smask = bd[5];
      end else if (!ba) begin
        case (bd[7:5])
          3'd0, 3'd4: m_rot = bd[7];
          3'd1, 3'd5: begin
            h = top_line(isr, off);
            if (h < 8) begin
              isr[h] = 0;
              if (bd[7:5] == 3'd5) off = 3'(h + 1);
            end
          end
          3'd3: isr[bd[2:0]] = 0;
          3'd6: off = bd[2:0] + 3'd1;
          3'd7: begin off = bd[2:0] + 3'd1; isr[bd[2:0]] = 0; end
          default: ;
        endcase
      end else begin
        case (m_seq)
          0: m_imr = bd;
          1: begin m_base = bd[7:3]; m_seq = 2; end
          2: m_seq = m_need4 ? 3 : 0;
          default: begin m_sfnm = bd[4]; m_aeoi = bd[1]; m_seq = 0; end
        endcase
      end
    end
    m_isr = isr; m_off = off;
    chk(req_clr == e_clr, tag, "req_clr", req_clr, e_clr);
    chk(ack_vector == e_vec, tag, "ack_vector", ack_vector, e_vec);
    @(negedge clk);
    bus_valid = 0; ack_valid = 0;
    #1;
    chk(isr_o == m_isr, tag, "isr", isr_o, m_isr);
    chk(imr_o == m_imr, tag, "imr", imr_o, m_imr);
    chk(prio_off == m_off, tag, "offset", prio_off, m_off);
    chk(sfnm_o == m_sfnm && smask_o == m_smask, tag, "flags",
        {sfnm_o, smask_o}, {m_sfnm, m_smask});
    chk(int_req == (is_init ? 1'b0 : wv), tag, "int_req", int_req, is_init ? 1'b0 : wv);
    if (is_rd) chk(rsp_valid && rsp_data == e_rsp, tag, "rsp_data", rsp_data, e_rsp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // reset state
    chk(isr_o == 0 && imr_o == 0 && prio_off == 0, "R1", "reset regs", {isr_o, imr_o}, 0);
    chk(!rsp_valid && bus_ready && !int_req && req_clr == 0, "R1", "reset outputs",
        {rsp_valid, bus_ready, int_req}, 3'b010);
    chk(ack_vector == 8'd7, "R10", "reset spurious vector", ack_vector, 8'd7);

    // R1 R2: init with fourth word, auto-EOI
    op(1,1,0,8'h11, 0,0,0,8'h00, "R1");
    op(1,1,1,8'h48, 0,0,0,8'h00, "R2");
    op(1,1,1,8'h04, 0,0,0,8'h00, "R2");
    op(1,1,1,8'h13, 0,0,0,8'h00, "R2");
    op(0,0,0,8'h00, 1,1,3'd3,8'h08, "R8");   // vector 0x4B
    // R9: auto-EOI without rotation, then with rotation
    op(1,1,0,8'h80, 0,0,0,8'h00, "R5");
    op(0,0,0,8'h00, 1,1,3'd6,8'h40, "R9");
    chk(prio_off == 3'd7, "R9", "rotate on auto-EOI", prio_off, 3'd7);
    op(1,1,0,8'h00, 0,0,0,8'h00, "R5");
    // R2 R3: init without fourth word, then mask load
    op(1,1,0,8'h10, 0,0,0,8'h00, "R1");
    op(1,1,1,8'h20, 0,0,0,8'h00, "R2");
    op(1,1,1,8'hFF, 0,0,0,8'h00, "R2");
    op(1,1,1,8'h5A, 0,0,0,8'h00, "R3");
    chk(imr_o == 8'h5A, "R3", "mask after short init", imr_o, 8'h5A);
    // R8: acknowledges in normal mode
    op(0,0,0,8'h00, 1,1,3'd1,8'h02, "R8");
    op(0,0,0,8'h00, 1,1,3'd4,8'h10, "R8");
    op(0,0,0,8'h00, 1,1,3'd6,8'h40, "R8");
    // R7 R6
    op(1,1,0,8'hC3, 0,0,0,8'h00, "R7");
    op(1,1,0,8'h20, 0,0,0,8'h00, "R6");
    chk(isr_o == 8'h42, "R6", "non-specific EOI from offset 4", isr_o, 8'h42);
    op(1,1,0,8'hA0, 0,0,0,8'h00, "R6");
    chk(isr_o == 8'h02 && prio_off == 3'd7, "R6", "rotating EOI", {isr_o, prio_off}, {8'h02, 3'd7});
    op(1,1,0,8'h61, 0,0,0,8'h00, "R7");
    op(1,1,0,8'h20, 0,0,0,8'h00, "R6");
    op(1,1,0,8'h40, 0,0,0,8'h00, "R7");
    op(1,1,0,8'hE5, 0,0,0,8'h00, "R7");
    chk(prio_off == 3'd6, "R7", "rotate specific offset", prio_off, 3'd6);
    // R4 R11: read-select and special mask
    op(0,0,0,8'h00, 1,1,3'd2,8'h04, "R8");
    op(1,1,0,8'h0B, 0,0,0,8'h00, "R4");
    op(0,0,0,8'h00, 0,0,0,8'h99, "R11");
    op(1,1,0,8'h09, 0,0,0,8'h00, "R4");
    op(0,0,0,8'h00, 0,0,0,8'h99, "R11");
    op(1,1,0,8'h0A, 0,0,0,8'h00, "R4");
    op(0,0,0,8'h00, 0,0,0,8'h99, "R11");
    op(0,0,1,8'h00, 0,0,0,8'h99, "R11");
    op(1,1,0,8'h68, 0,0,0,8'h00, "R4");
    op(1,1,0,8'h28, 0,0,0,8'h00, "R4");
    chk(smask_o, "R4", "special mask held when permit clear", smask_o, 1'b1);
    // R12: poll with and without winner
    op(0,0,0,8'h00, 1,1,3'd5,8'h20, "R8");
    op(1,1,0,8'h0C, 0,0,0,8'h00, "R12");
    op(0,0,1,8'h00, 0,1,3'd5,8'h20, "R12");
    op(0,0,1,8'h00, 0,1,3'd5,8'h20, "R12");
    op(1,1,0,8'h0C, 0,0,0,8'h00, "R12");
    op(0,0,0,8'h00, 0,0,3'd0,8'h00, "R12");
    // R10: spurious acknowledge
    op(0,0,0,8'h00, 1,1,3'd2,8'h04, "R8");
    op(0,0,0,8'h00, 1,0,3'd4,8'h00, "R10");
    // R13: acknowledge and non-specific EOI together
    op(1,1,0,8'h10, 0,0,0,8'h00, "R1");
    op(1,1,1,8'h00, 0,0,0,8'h00, "R2");
    op(1,1,1,8'h00, 0,0,0,8'h00, "R2");
    op(0,0,0,8'h00, 1,1,3'd5,8'h20, "R8");
    op(1,1,0,8'h20, 1,1,3'd2,8'h04, "R13");
    chk(isr_o == 8'h20, "R13", "ack applied before EOI", isr_o, 8'h20);
    // R1: init drops int_req while a winner is present
    op(0,0,0,8'h00, 0,1,3'd1,8'h02, "R1");
    op(1,1,0,8'h10, 0,1,3'd1,8'h02, "R1");
    op(1,1,1,8'h00, 0,0,0,8'h00, "R2");
    op(1,1,1,8'h00, 0,0,0,8'h00, "R2");
    op(1,1,1,8'hA5, 0,0,0,8'h00, "R3");

    // R14: response back-pressure
    @(negedge clk);
    rsp_ready = 0; bus_valid = 1; bus_write = 0; bus_addr = 1;
    @(negedge clk);
    bus_valid = 0;
    #1;
    held = rsp_data;
    chk(rsp_valid && held == m_imr, "R14", "held response", held, m_imr);
    chk(!bus_ready, "R14", "bus stalled", bus_ready, 1'b0);
    bus_valid = 1; bus_write = 1; bus_addr = 1; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid && rsp_data == held, "R14", "data stable", rsp_data, held);
    chk(imr_o == m_imr, "R14", "write not taken while stalled", imr_o, m_imr);
    bus_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    #1;
    chk(!rsp_valid, "R14", "response released", rsp_valid, 1'b0);

    // random mix, acknowledges often coincide with writes (R13)
    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      bit bv, bw, ba;
      d = 8'($urandom);
      bv = ($urandom % 4) != 0;
      bw = ($urandom % 3) != 0;
      ba = $urandom % 2;
      if (bw && !ba && d[4] && ($urandom % 10) != 0) d[4] = 0;
      op(bv, bw, ba, d, ($urandom % 2) == 1, ($urandom % 4) != 0,
         3'($urandom), 8'($urandom), "R13");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule